// File: doc/BRIEF.md
# DRAM Bank Row/Column Sequencer

This block drives one DRAM bank. It turns single read or write requests from a client into the command sequence the bank needs: open a row, access a column, and close the row before a different one can be opened. Row and column addresses go out on one shared address bus. The row goes out with the open command and the column goes out later with the access command.

The sequencer follows an open-page policy. After an access, the row stays open. A later request to the same row goes straight to the column access. A request to a different row first closes the open row and then opens the new one. After reset no row is open, so the first request opens its row without a close. Each phase has its own programmable wait count, which sets the number of cycles from one command to the next.

The client side is a valid/ready request channel that handles one request at a time. Back-pressure rules:
- `req_ready` is high only while the sequencer is idle.
- A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` then stays low until that request has finished.
- The client must hold the request fields stable while `req_valid` is high.
- The client must keep the three wait counts stable while a request is being served.

Read data comes back as a one-cycle pulse on `rsp_valid`. This pulse has no back-pressure.

Top module: `dram_row_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_ready` is 1, `mem_cmd` is idle (code 0), `rsp_valid` is 0, and no row is considered open.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` is 0 until the cycle in which the request completes, and in that cycle it is 1 again.
- R3: When no row is open, the cycle after acceptance carries an open command (code 1) with the request row on `mem_addr`. No close command comes before it.
- R4: When the open row equals the request row, the cycle after acceptance carries the column command: read code 2 or write code 3, with the column zero-extended on `mem_addr`.
- R5: When a different row is open, the cycle after acceptance carries a close command (code 4). It is followed `t_pre` cycles later by an open command for the new row.
- R6: After an open command, the column command follows `t_act` cycles later. A wait count of 0 acts as 1.
- R7: For a read, `rsp_valid` is 1 for exactly one cycle, `t_col` cycles after the read command. `rsp_rdata` carries the bank's data for that row and column, and `req_ready` rises in the same cycle.
- R8: For a write, `mem_wdata` carries the request data in the cycle of the write command. The request completes `t_col` cycles later with no response pulse. A later read of that location returns the written data.
- R9: Commands are always legal for the bank. An open is issued only when the bank is closed. Column and close commands are issued only when a row is open. In every other cycle the command is idle (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | DATA_W | Read data |
| t_pre | input | CNT_W | Cycles from close to next open |
| t_act | input | CNT_W | Cycles from open to column access |
| t_col | input | CNT_W | Cycles from column access to completion |
| mem_cmd | output | 3 | Bank command: 0 idle, 1 open, 2 read, 3 write, 4 close |
| mem_addr | output | ADDR_W | Shared row/column address |
| mem_wdata | output | DATA_W | Write data to bank |
| mem_rdata | input | DATA_W | Read data from bank |

## Verification
The hardest situation to reach is a close/open sequence with unusual timing: a row miss while a row is open, with some wait counts at zero, where a late command could still look legal. The stimulus first walks the three paths (closed bank, hit, miss) with chosen timings, including all-zero counts. It then runs a long random stream limited to four rows, so that hits and misses both occur often, and draws new wait counts in the range 0 to 5 for every request. A bank model in the bench rejects any out-of-order command. A schedule computed at acceptance predicts every command cycle, address and response pulse.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } bank_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_COL
  } seq_state_e;
endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  // a length of zero behaves as one cycle
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close,
  input  logic [ROW_W-1:0] set_row,
  input  logic [ROW_W-1:0] look_row,
  output logic             open_valid,
  output logic             hit
);
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_valid <= 1'b0;
      open_row   <= '0;
    end else if (open_set) begin
      open_valid <= 1'b1;
      open_row   <= set_row;
    end else if (close) begin
      open_valid <= 1'b0;
    end
  end

  assign hit = open_valid && (open_row == look_row);
endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  t_pre,
  input  logic [CNT_W-1:0]  t_act,
  input  logic [CNT_W-1:0]  t_col,
  output logic [2:0]        mem_cmd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int ROW_PAD = ADDR_W - ROW_W;
  localparam int COL_PAD = ADDR_W - COL_W;

  seq_state_e state, nxt_state;
  bank_cmd_e  cmd_q, nxt_cmd;
  logic [ADDR_W-1:0] addr_q, nxt_addr;
  logic [DATA_W-1:0] wdata_q;

  logic              h_write;
  logic [ROW_W-1:0]  h_row;
  logic [COL_W-1:0]  h_col;
  logic [DATA_W-1:0] h_wdata;

  logic              s_write;
  logic [ROW_W-1:0]  s_row;
  logic [COL_W-1:0]  s_col;
  logic [DATA_W-1:0] s_wdata;
  logic [ADDR_W-1:0] row_ext, col_ext;

  logic go_pre, go_act, go_col, finish, accept;
  logic open_valid, hit, tmr_done;
  logic [CNT_W-1:0] tmr_len;

  // In idle the live request is used; later phases use the held copy
  assign accept  = (state == ST_IDLE) && req_valid;
  assign s_write = (state == ST_IDLE) ? req_write : h_write;
  assign s_row   = (state == ST_IDLE) ? req_row   : h_row;
  assign s_col   = (state == ST_IDLE) ? req_col   : h_col;
  assign s_wdata = (state == ST_IDLE) ? req_wdata : h_wdata;

  generate
    if (ROW_PAD > 0) begin : g_row_pad
      assign row_ext = {{ROW_PAD{1'b0}}, s_row};
    end else begin : g_row_eq
      assign row_ext = s_row;
    end
    if (COL_PAD > 0) begin : g_col_pad
      assign col_ext = {{COL_PAD{1'b0}}, s_col};
    end else begin : g_col_eq
      assign col_ext = s_col;
    end
  endgenerate

  always_comb begin
    go_pre = 1'b0;
    go_act = 1'b0;
    go_col = 1'b0;
    finish = 1'b0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        if (hit)             go_col = 1'b1;
        else if (open_valid) go_pre = 1'b1;
        else                 go_act = 1'b1;
      end
      ST_PRE:  go_act = tmr_done;
      ST_ACT:  go_col = tmr_done;
      ST_COL:  finish = tmr_done;
      default: ;
    endcase
  end

  always_comb begin
    nxt_state = state;
    nxt_cmd   = CMD_NOP;
    nxt_addr  = addr_q;
    tmr_len   = t_col;
    if (go_pre) begin
      nxt_state = ST_PRE;
      nxt_cmd   = CMD_PRE;
      tmr_len   = t_pre;
    end else if (go_act) begin
      nxt_state = ST_ACT;
      nxt_cmd   = CMD_ACT;
      nxt_addr  = row_ext;
      tmr_len   = t_act;
    end else if (go_col) begin
      nxt_state = ST_COL;
      nxt_cmd   = s_write ? CMD_WR : CMD_RD;
      nxt_addr  = col_ext;
    end else if (finish) begin
      nxt_state = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_q     <= CMD_NOP;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      h_write   <= 1'b0;
      h_row     <= '0;
      h_col     <= '0;
      h_wdata   <= '0;
    end else begin
      state     <= nxt_state;
      cmd_q     <= nxt_cmd;
      addr_q    <= nxt_addr;
      rsp_valid <= finish && !h_write;
      if (finish && !h_write) rsp_rdata <= mem_rdata;
      if (go_col) wdata_q <= s_wdata;
      if (accept) begin
        h_write <= req_write;
        h_row   <= req_row;
        h_col   <= req_col;
        h_wdata <= req_wdata;
      end
    end
  end

  dram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (go_pre | go_act | go_col),
    .len   (tmr_len),
    .done  (tmr_done)
  );

  dram_open_row #(.ROW_W(ROW_W)) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_set   (go_act),
    .close      (go_pre),
    .set_row    (s_row),
    .look_row   (req_row),
    .open_valid (open_valid),
    .hit        (hit)
  );

  assign req_ready = (state == ST_IDLE);
  assign mem_cmd   = cmd_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/dram_row_seq_chk.sv
module dram_row_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [2:0] mem_cmd
);
  logic sh_open;

  always_ff @(posedge clk) begin
    if (!rst_n)               sh_open <= 1'b0;
    else if (mem_cmd == 3'd1) sh_open <= 1'b1;
    else if (mem_cmd == 3'd4) sh_open <= 1'b0;
  end

  // R9
  act_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'd1) |-> !sh_open);
  // R9
  col_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'd2 || mem_cmd == 3'd3) |-> sh_open);
  // R9
  pre_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'd4) |-> sh_open);
  // R9
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd <= 3'd4);
  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R7
  rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind dram_row_seq dram_row_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_cmd   (mem_cmd)
);

// File: tb/tb_dram_row_seq.sv
`timescale 1ns/1ps
module tb_dram_row_seq;
  localparam int ROW_W = 4, COL_W = 3, DATA_W = 8, CNT_W = 6, ADDR_W = 4;
  localparam int NCOL = 1 << COL_W;
  localparam int NCELL = (1 << ROW_W) * NCOL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [CNT_W-1:0] t_pre = 6'd1, t_act = 6'd1, t_col = 6'd1;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [2:0] mem_cmd;
  logic [ADDR_W-1:0] mem_addr;

  dram_row_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .t_pre(t_pre), .t_act(t_act),
    .t_col(t_col), .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(int i);
    return DATA_W'((i * 37 + 5) & 255);
  endfunction

  // behavioural bank
  logic [DATA_W-1:0] cells [NCELL];
  int bank_open = -1, rd_col = 0;
  always @(posedge clk) if (rst_n) begin
    case (mem_cmd)
      3'd1: begin chk("R9 open while closed", int'(bank_open < 0), 1); bank_open = int'(mem_addr); end
      3'd4: begin chk("R9 close while open", int'(bank_open >= 0), 1); bank_open = -1; end
      3'd2: begin chk("R9 read while open", int'(bank_open >= 0), 1); rd_col = int'(mem_addr); end
      3'd3: begin
        chk("R9 write while open", int'(bank_open >= 0), 1);
        if (bank_open >= 0) cells[bank_open * NCOL + int'(mem_addr)] = mem_wdata;
      end
      default: ;
    endcase
  end
  assign mem_rdata = (bank_open >= 0) ?
    cells[bank_open * NCOL + ((mem_cmd == 3'd2) ? int'(mem_addr) : rd_col)] : '0;

  // reference schedule
  int exp_cmd [int];
  int exp_addr [int];
  string exp_tag [int];
  int exp_wd [int];
  int exp_rsp [int];
  int busy_until = 0;
  logic [DATA_W-1:0] ref_mem [NCELL];
  bit ref_open_v = 0;
  int ref_open_row = 0;

  function automatic int clamp(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic plan(int h);
    int t, c, tp, ta, tc, idx;
    t = h + 1; tp = clamp(int'(t_pre)); ta = clamp(int'(t_act)); tc = clamp(int'(t_col));
    idx = int'(req_row) * NCOL + int'(req_col);
    if (ref_open_v && ref_open_row == int'(req_row)) begin
      c = t;
    end else if (ref_open_v) begin
      exp_cmd[t] = 4; exp_addr[t] = -1; exp_tag[t] = "R5";
      exp_cmd[t+tp] = 1; exp_addr[t+tp] = int'(req_row); exp_tag[t+tp] = "R5";
      c = t + tp + ta;
    end else begin
      exp_cmd[t] = 1; exp_addr[t] = int'(req_row); exp_tag[t] = "R3";
      c = t + ta;
    end
    exp_cmd[c] = req_write ? 3 : 2; exp_addr[c] = int'(req_col);
    exp_tag[c] = (c == t) ? "R4" : "R6";
    if (req_write) begin
      exp_wd[c] = int'(req_wdata);
      ref_mem[idx] = req_wdata;
    end else begin
      exp_rsp[c + tc] = int'(ref_mem[idx]);
    end
    busy_until = c + tc;
    ref_open_v = 1; ref_open_row = int'(req_row);
  endtask

  // per-cycle comparison, between the edge and the drive point
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      int ec;
      ec = exp_cmd.exists(cyc) ? exp_cmd[cyc] : 0;
      chk(exp_cmd.exists(cyc) ? exp_tag[cyc] : "R9 idle", int'(mem_cmd), ec);
      if (ec != 0 && exp_addr[cyc] >= 0) chk("R4 addr", int'(mem_addr), exp_addr[cyc]);
      if (ec == 3) chk("R8 wdata", int'(mem_wdata), exp_wd[cyc]);
      chk("R2 ready", int'(req_ready), int'(cyc >= busy_until));
      chk("R7 rsp_valid", int'(rsp_valid), int'(exp_rsp.exists(cyc)));
      if (exp_rsp.exists(cyc)) chk("R7 rdata", int'(rsp_rdata), exp_rsp[cyc]);
    end
  end

  task automatic do_req(bit w, int row, int col, int wd, int tp, int ta, int tc);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    t_pre = CNT_W'(tp); t_act = CNT_W'(ta); t_col = CNT_W'(tc);
    req_write = w; req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = DATA_W'(wd);
    req_valid = 1'b1;
    plan(cyc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCELL; i++) begin cells[i] = pat(i); ref_mem[i] = pat(i); end
    repeat (4) @(negedge clk);
    chk("R1 ready in reset", int'(req_ready), 1);
    chk("R1 rsp in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd after reset", int'(mem_cmd), 0);
    repeat (3) @(negedge clk);
    do_req(0, 3, 2, 0, 2, 3, 2);   // R3 closed bank
    do_req(0, 3, 5, 0, 2, 3, 2);   // R4 hit
    do_req(1, 3, 5, 8'hA5, 1, 1, 3); // R8 write hit
    do_req(0, 3, 5, 0, 1, 1, 1);   // R8 read back
    do_req(0, 9, 1, 0, 3, 4, 2);   // R5 miss
    do_req(0, 9, 0, 0, 0, 0, 0);   // R6 zero counts
    do_req(1, 2, 7, 8'h3C, 0, 0, 0); // R5 R6 miss with zeros
    do_req(0, 2, 7, 0, 5, 5, 5);   // R7
    repeat (5) @(negedge clk);
    for (int k = 0; k < 300; k++) begin
      do_req(bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
             int'($urandom_range(0, NCOL - 1)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
             int'($urandom_range(0, 5)));
      if ($urandom_range(0, 3) == 0) repeat (2) @(negedge clk);
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule